// File: doc/BRIEF.md
# Transceiver Reference Clock Switch Sequencer

This block moves a serial transceiver channel onto a different reference clock without software stepping through the procedure. It drives the channel's byte-wide reconfiguration port as a bus master. One `start` pulse loads the inputs: the address of the lookup register that holds the mux pattern for the chosen clock, a selector for which nibble of that register holds the pattern, and an optional set of new configuration values. The sequencer then runs a fixed script of bus transactions and handshakes. It keeps the channel in digital reset for the whole script and releases it only at the end.

The script runs in this order:

1. It holds the analog section in reset through an attribute send.
2. It copies the looked-up pattern into the low nibble of the clock mux register with a read-modify-write.
3. It runs an external analog reset handshake.
4. It asks the channel to reload its profile and polls the reload bit until it clears.
5. If a new configuration is requested, it clears the sticky profile-loaded flag and sends the configuration attributes in a fixed order.

Any wait that lasts longer than a programmable limit stops the script in a fault state. In that state the channel stays in reset.

States and transitions:

- `ST_IDLE` and `ST_FAULT` move to `ST_PRST_DAT` on `start`.
- The script continues `ST_PRST_DAT` → `ST_PRST_CODE` → `ST_LOOKUP_RD` → `ST_MUX_RD` → `ST_MUX_WR` → `ST_ANA_RST`. Each of these steps advances when its bus transaction completes.
- `ST_ANA_RST` moves to `ST_RELOAD_WR` on acknowledge, or to `ST_FAULT` when the wait limit expires.
- `ST_RELOAD_WR` moves to `ST_POLL_RD`.
- `ST_POLL_RD` re-reads the reload register while its bit 0 is 1. When the bit reads 0, it moves to `ST_FLAG_CLR` if a new configuration was requested, and to `ST_RELEASE` otherwise. If the limit expires while the bit is still 1, it moves to `ST_FAULT`.
- `ST_FLAG_CLR` moves to `ST_ATTR_DAT`.
- `ST_ATTR_DAT` ↔ `ST_ATTR_CODE` loop once per attribute step. After the last step the loop exits to `ST_RELEASE`.
- `ST_RELEASE` returns to `ST_IDLE`.

Top module: `refclk_switch_seq`

## Requirements
- R1: `dig_rst` is 0 after reset and while idle. It is 1 from the cycle after an accepted `start` for as long as `busy` is 1, except in the final cycle. In that final cycle `done` is 1 and `dig_rst` is already 0.
- R2: An attribute send is two writes: the value to address 0x84, then the attribute code to address 0x86. The first two writes of every run send code 0x01 with value 0x01, before any read.
- R3: The sequencer then reads `lookup_addr` and captures a 4-bit pattern. With `lookup_hi` = 0 the pattern is bits [3:0]; with `lookup_hi` = 1 it is bits [7:4].
- R4: It then reads address 0xEC and writes back a byte whose bits [3:0] are the pattern and whose bits [7:4] are the upper nibble just read.
- R5: After the mux write, `ana_rst_req` stays high with no bus traffic until `ana_rst_ack` is seen. No further bus traffic happens before the acknowledge.
- R6: It then writes 0x01 to address 0x91 and reads 0x91 again and again until bit 0 reads 0.
- R7: When `new_cfg` is 1, it next writes 0x80 to address 0x8A, a write-one-to-clear of bit 7. It then sends these attributes, in this order:
  - 0x05 with `tx_ratio`
  - 0x06 with `rx_ratio`
  - 0x14 with `serdes_mode`
  - 0x15 with `tx_eq`
  - 0x11 with value 0x01
  - 0x01 with value 0x00
- R8: When `cal_en` is 0, the 0x11 attribute is left out and the other steps keep their order.
- R9: When `new_cfg` is 0, no write follows the poll: the run ends right after bit 0 of 0x91 reads 0.
- R10: If the acknowledge wait or the poll lasts `wait_limit` cycles or more, the sequencer enters a fault state. In that state `err` is 1, `dig_rst` stays 1, `busy` is 0, and no further bus traffic or analog request is issued. A new `start` restarts the script.
- R11: A `start` while `busy` is 1 is ignored. `done` is a pulse of exactly one cycle per completed run.
- R12: At most one bus transaction is outstanding. Read and write are never both high. The address and write data hold steady while `avm_waitrequest` is 1. A read completes only on `avm_readdatavalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a switch |
| lookup_addr | input | AW | Address of the lookup register for the chosen clock |
| lookup_hi | input | 1 | Takes the pattern from the upper nibble when 1 |
| new_cfg | input | 1 | Sends the configuration attributes after the reload |
| cal_en | input | 1 | Includes the calibration attribute |
| tx_ratio | input | DW | Value for the TX rate ratio attribute |
| rx_ratio | input | DW | Value for the RX rate ratio attribute |
| serdes_mode | input | DW | Value for the serializer ratio / line coding attribute |
| tx_eq | input | DW | Value for the TX equalization attribute |
| wait_limit | input | CW | Cycle bound for the acknowledge wait and the poll |
| avm_address | output | AW | Reconfiguration port address |
| avm_read | output | 1 | Read request |
| avm_write | output | 1 | Write request |
| avm_writedata | output | DW | Write data |
| avm_readdata | input | DW | Read data |
| avm_waitrequest | input | 1 | Port stall |
| avm_readdatavalid | input | 1 | Read data valid |
| ana_rst_req | output | 1 | Analog reset sub-sequence request |
| ana_rst_ack | input | 1 | Analog reset sub-sequence acknowledge |
| dig_rst | output | 1 | Channel digital reset |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Fault: a wait limit expired |

## Verification
The bench tries the script with lookup bytes whose two nibbles differ. It also uses mux bytes whose upper nibble is non-zero. With these inputs, a wrong nibble selection or a write that clobbers bits [7:4] changes the logged write data.

The vectors cover every combination of `new_cfg` and `cal_en` that matters. This shows the write log length and order for the plain reload, the full attribute block, and the block with the calibration step left out. Poll counts of 0, 1, 3 and 5 separate an early exit from the poll loop from one that runs forever. Directed runs cover:

- a missing acknowledge;
- a reload bit that never clears;
- a `start` with different inputs arriving mid-run;
- a restart from the fault state.

// File: rtl/refclk_sw_pkg.sv
package refclk_sw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRST_DAT,
        ST_PRST_CODE,
        ST_LOOKUP_RD,
        ST_MUX_RD,
        ST_MUX_WR,
        ST_ANA_RST,
        ST_RELOAD_WR,
        ST_POLL_RD,
        ST_FLAG_CLR,
        ST_ATTR_DAT,
        ST_ATTR_CODE,
        ST_RELEASE,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_WR,
        BUS_RD,
        BUS_RDWAIT
    } bus_state_e;

    typedef enum logic [2:0] {
        AT_TX_RATIO,
        AT_RX_RATIO,
        AT_SERDES,
        AT_TX_EQ,
        AT_CAL,
        AT_PWR_UP
    } attr_step_e;

    localparam logic [7:0] CODE_RESET    = 8'h01;
    localparam logic [7:0] CODE_TX_RATIO = 8'h05;
    localparam logic [7:0] CODE_RX_RATIO = 8'h06;
    localparam logic [7:0] CODE_SERDES   = 8'h14;
    localparam logic [7:0] CODE_TX_EQ    = 8'h15;
    localparam logic [7:0] CODE_CAL      = 8'h11;

endpackage

// File: rtl/seq_bus_port.sv
module seq_bus_port
    import refclk_sw_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_done,
    output logic [DW-1:0] cmd_rdata,
    output logic [AW-1:0] avm_address,
    output logic          avm_read,
    output logic          avm_write,
    output logic [DW-1:0] avm_writedata,
    input  logic [DW-1:0] avm_readdata,
    input  logic          avm_waitrequest,
    input  logic          avm_readdatavalid
);

    bus_state_e    bst;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bst     <= BUS_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (bst)
                BUS_IDLE: begin
                    if (cmd_go) begin
                        bst     <= cmd_wr ? BUS_WR : BUS_RD;
                        addr_q  <= cmd_addr;
                        wdata_q <= cmd_wdata;
                    end
                end
                BUS_WR:     if (!avm_waitrequest) bst <= BUS_IDLE;
                BUS_RD:     if (!avm_waitrequest) bst <= BUS_RDWAIT;
                BUS_RDWAIT: if (avm_readdatavalid) bst <= BUS_IDLE;
                default:    bst <= BUS_IDLE;
            endcase
        end
    end

    always_comb begin
        avm_address   = addr_q;
        avm_writedata = wdata_q;
        avm_write     = (bst == BUS_WR);
        avm_read      = (bst == BUS_RD);
        cmd_rdata     = avm_readdata;
        cmd_done      = ((bst == BUS_WR) && !avm_waitrequest)
                      || ((bst == BUS_RDWAIT) && avm_readdatavalid);
    end

endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != {CW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt >= limit);

endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
    import refclk_sw_pkg::*;
#(
    parameter int             AW             = 8,
    parameter int             DW             = 8,
    parameter int             CW             = 16,
    parameter logic [AW-1:0]  MUX_ADDR       = 'hEC,
    parameter logic [AW-1:0]  RELOAD_ADDR    = 'h91,
    parameter logic [AW-1:0]  FLAG_ADDR      = 'h8A,
    parameter logic [AW-1:0]  ATTR_DAT_ADDR  = 'h84,
    parameter logic [AW-1:0]  ATTR_CODE_ADDR = 'h86,
    parameter int             FLAG_BIT       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] lookup_addr,
    input  logic          lookup_hi,
    input  logic          new_cfg,
    input  logic          cal_en,
    input  logic [DW-1:0] tx_ratio,
    input  logic [DW-1:0] rx_ratio,
    input  logic [DW-1:0] serdes_mode,
    input  logic [DW-1:0] tx_eq,
    input  logic [CW-1:0] wait_limit,
    output logic [AW-1:0] avm_address,
    output logic          avm_read,
    output logic          avm_write,
    output logic [DW-1:0] avm_writedata,
    input  logic [DW-1:0] avm_readdata,
    input  logic          avm_waitrequest,
    input  logic          avm_readdatavalid,
    output logic          ana_rst_req,
    input  logic          ana_rst_ack,
    output logic          dig_rst,
    output logic          busy,
    output logic          done,
    output logic          err
);

    localparam int NIB_W = DW / 2;
    localparam logic [DW-1:0] ONE_BYTE  = DW'(1);
    localparam logic [DW-1:0] FLAG_MASK = DW'(1) << FLAG_BIT;

    seq_state_e    state;
    attr_step_e    step;
    logic          issued;
    logic [AW-1:0] lk_addr_q;
    logic          lk_hi_q, new_q, cal_q;
    logic [DW-1:0] txr_q, rxr_q, sdm_q, eq_q;
    logic [NIB_W-1:0] nib_q;
    logic [DW-1:0] mux_q;

    logic          cmd_bus, cmd_go, cmd_wr, cmd_done;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata, cmd_rdata;
    logic [DW-1:0] attr_dat, attr_code;
    logic          tmr_run, tmr_expired;

    assign cmd_go = cmd_bus && !issued;

    seq_bus_port #(.AW(AW), .DW(DW)) u_bus (
        .clk               (clk),
        .rst_n             (rst_n),
        .cmd_go            (cmd_go),
        .cmd_wr            (cmd_wr),
        .cmd_addr          (cmd_addr),
        .cmd_wdata         (cmd_wdata),
        .cmd_done          (cmd_done),
        .cmd_rdata         (cmd_rdata),
        .avm_address       (avm_address),
        .avm_read          (avm_read),
        .avm_write         (avm_write),
        .avm_writedata     (avm_writedata),
        .avm_readdata      (avm_readdata),
        .avm_waitrequest   (avm_waitrequest),
        .avm_readdatavalid (avm_readdatavalid)
    );

    seq_wait_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .limit   (wait_limit),
        .expired (tmr_expired)
    );

    // attribute step -> value and code
    always_comb begin
        attr_dat  = '0;
        attr_code = '0;
        unique case (step)
            AT_TX_RATIO: begin attr_dat = txr_q;    attr_code = DW'(CODE_TX_RATIO); end
            AT_RX_RATIO: begin attr_dat = rxr_q;    attr_code = DW'(CODE_RX_RATIO); end
            AT_SERDES:   begin attr_dat = sdm_q;    attr_code = DW'(CODE_SERDES);   end
            AT_TX_EQ:    begin attr_dat = eq_q;     attr_code = DW'(CODE_TX_EQ);    end
            AT_CAL:      begin attr_dat = ONE_BYTE; attr_code = DW'(CODE_CAL);      end
            AT_PWR_UP:   begin attr_dat = '0;       attr_code = DW'(CODE_RESET);    end
            default:     begin attr_dat = '0;       attr_code = '0;                 end
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step      <= AT_TX_RATIO;
            issued    <= 1'b0;
            lk_addr_q <= '0;
            lk_hi_q   <= 1'b0;
            new_q     <= 1'b0;
            cal_q     <= 1'b0;
            txr_q     <= '0;
            rxr_q     <= '0;
            sdm_q     <= '0;
            eq_q      <= '0;
            nib_q     <= '0;
            mux_q     <= '0;
        end else begin
            if (cmd_go)
                issued <= 1'b1;
            else if (cmd_done)
                issued <= 1'b0;

            unique case (state)
                ST_IDLE, ST_FAULT: begin
                    if (start) begin
                        lk_addr_q <= lookup_addr;
                        lk_hi_q   <= lookup_hi;
                        new_q     <= new_cfg;
                        cal_q     <= cal_en;
                        txr_q     <= tx_ratio;
                        rxr_q     <= rx_ratio;
                        sdm_q     <= serdes_mode;
                        eq_q      <= tx_eq;
                        state     <= ST_PRST_DAT;
                    end
                end
                ST_PRST_DAT:  if (cmd_done) state <= ST_PRST_CODE;
                ST_PRST_CODE: if (cmd_done) state <= ST_LOOKUP_RD;
                ST_LOOKUP_RD: begin
                    if (cmd_done) begin
                        nib_q <= lk_hi_q ? cmd_rdata[DW-1 -: NIB_W] : cmd_rdata[NIB_W-1:0];
                        state <= ST_MUX_RD;
                    end
                end
                ST_MUX_RD: begin
                    if (cmd_done) begin
                        mux_q <= {cmd_rdata[DW-1:NIB_W], nib_q};
                        state <= ST_MUX_WR;
                    end
                end
                ST_MUX_WR: if (cmd_done) state <= ST_ANA_RST;
                ST_ANA_RST: begin
                    if (ana_rst_ack)
                        state <= ST_RELOAD_WR;
                    else if (tmr_expired)
                        state <= ST_FAULT;
                end
                ST_RELOAD_WR: if (cmd_done) state <= ST_POLL_RD;
                ST_POLL_RD: begin
                    if (cmd_done) begin
                        if (!cmd_rdata[0])
                            state <= new_q ? ST_FLAG_CLR : ST_RELEASE;
                        else if (tmr_expired)
                            state <= ST_FAULT;
                    end
                end
                ST_FLAG_CLR: begin
                    if (cmd_done) begin
                        step  <= AT_TX_RATIO;
                        state <= ST_ATTR_DAT;
                    end
                end
                ST_ATTR_DAT: if (cmd_done) state <= ST_ATTR_CODE;
                ST_ATTR_CODE: begin
                    if (cmd_done) begin
                        if (step == AT_PWR_UP) begin
                            state <= ST_RELEASE;
                        end else begin
                            state <= ST_ATTR_DAT;
                            unique case (step)
                                AT_TX_RATIO: step <= AT_RX_RATIO;
                                AT_RX_RATIO: step <= AT_SERDES;
                                AT_SERDES:   step <= AT_TX_EQ;
                                AT_TX_EQ:    step <= cal_q ? AT_CAL : AT_PWR_UP;
                                default:     step <= AT_PWR_UP;
                            endcase
                        end
                    end
                end
                ST_RELEASE: state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // outputs and bus command per state
    always_comb begin
        cmd_bus   = 1'b0;
        cmd_wr    = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        unique case (state)
            ST_PRST_DAT:  begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = ATTR_DAT_ADDR;  cmd_wdata = ONE_BYTE; end
            ST_PRST_CODE: begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = ATTR_CODE_ADDR; cmd_wdata = DW'(CODE_RESET); end
            ST_LOOKUP_RD: begin cmd_bus = 1'b1; cmd_addr = lk_addr_q; end
            ST_MUX_RD:    begin cmd_bus = 1'b1; cmd_addr = MUX_ADDR; end
            ST_MUX_WR:    begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = MUX_ADDR;       cmd_wdata = mux_q; end
            ST_RELOAD_WR: begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = RELOAD_ADDR;    cmd_wdata = ONE_BYTE; end
            ST_POLL_RD:   begin cmd_bus = 1'b1; cmd_addr = RELOAD_ADDR; end
            ST_FLAG_CLR:  begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = FLAG_ADDR;      cmd_wdata = FLAG_MASK; end
            ST_ATTR_DAT:  begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = ATTR_DAT_ADDR;  cmd_wdata = attr_dat; end
            ST_ATTR_CODE: begin cmd_bus = 1'b1; cmd_wr = 1'b1; cmd_addr = ATTR_CODE_ADDR; cmd_wdata = attr_code; end
            default: ;
        endcase

        tmr_run     = (state == ST_ANA_RST) || (state == ST_POLL_RD);
        ana_rst_req = (state == ST_ANA_RST);
        dig_rst     = (state != ST_IDLE) && (state != ST_RELEASE);
        busy        = (state != ST_IDLE) && (state != ST_FAULT);
        done        = (state == ST_RELEASE);
        err         = (state == ST_FAULT);
    end

endmodule

// File: rtl/refclk_switch_seq_chk.sv
module refclk_switch_seq_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] avm_address,
    input logic          avm_read,
    input logic          avm_write,
    input logic [DW-1:0] avm_writedata,
    input logic          avm_waitrequest,
    input logic          ana_rst_req,
    input logic          dig_rst,
    input logic          busy,
    input logic          done,
    input logic          err
);

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(avm_read && avm_write)); // R12

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (avm_read && avm_waitrequest) |=> (avm_read && $stable(avm_address))); // R12

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (avm_write && avm_waitrequest) |=>
            (avm_write && $stable(avm_address) && $stable(avm_writedata))); // R12

    AST_BUSY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> dig_rst); // R1

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dig_rst); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (dig_rst && !busy)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!avm_read && !avm_write && !ana_rst_req)); // R10

    AST_ANA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ana_rst_req |-> (!avm_read && !avm_write)); // R5

endmodule

bind refclk_switch_seq refclk_switch_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .avm_address     (avm_address),
    .avm_read        (avm_read),
    .avm_write       (avm_write),
    .avm_writedata   (avm_writedata),
    .avm_waitrequest (avm_waitrequest),
    .ana_rst_req     (ana_rst_req),
    .dig_rst         (dig_rst),
    .busy            (busy),
    .done            (done),
    .err             (err)
);

// File: tb/refclk_switch_seq_bench.sv
`timescale 1ns/1ps
module refclk_switch_seq_bench;

    typedef struct packed {
        logic [7:0] lk_addr;
        logic       lk_hi;
        logic       new_cfg;
        logic       cal_en;
        logic [7:0] lk_val;
        logic [7:0] mux_init;
        logic [7:0] tx;
        logic [7:0] rx;
        logic [7:0] sd;
        logic [7:0] eq;
        logic [7:0] polls;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{8'hEF, 1'b0, 1'b0, 1'b0, 8'h3A, 8'h5C, 8'h00, 8'h00, 8'h00, 8'h00, 8'd0},
        '{8'hEF, 1'b1, 1'b1, 1'b1, 8'hC7, 8'hF0, 8'h11, 8'h22, 8'h33, 8'h44, 8'd3},
        '{8'hE0, 1'b0, 1'b1, 1'b0, 8'h96, 8'h0F, 8'h55, 8'h66, 8'h77, 8'h88, 8'd1},
        '{8'hF3, 1'b1, 1'b0, 1'b1, 8'h5E, 8'hA3, 8'h99, 8'hAA, 8'hBB, 8'hCC, 8'd5}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  lookup_addr = '0;
    logic        lookup_hi = 1'b0, new_cfg = 1'b0, cal_en = 1'b0;
    logic [7:0]  tx_ratio = '0, rx_ratio = '0, serdes_mode = '0, tx_eq = '0;
    logic [15:0] wait_limit = 16'd1000;
    logic [7:0]  avm_address, avm_writedata, avm_readdata;
    logic        avm_read, avm_write, avm_waitrequest, avm_readdatavalid;
    logic        ana_rst_req, ana_rst_ack, dig_rst, busy, done, err;

    refclk_switch_seq u_refclk_switch_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lookup_addr(lookup_addr),
        .lookup_hi(lookup_hi), .new_cfg(new_cfg), .cal_en(cal_en),
        .tx_ratio(tx_ratio), .rx_ratio(rx_ratio), .serdes_mode(serdes_mode),
        .tx_eq(tx_eq), .wait_limit(wait_limit), .avm_address(avm_address),
        .avm_read(avm_read), .avm_write(avm_write), .avm_writedata(avm_writedata),
        .avm_readdata(avm_readdata), .avm_waitrequest(avm_waitrequest),
        .avm_readdatavalid(avm_readdatavalid), .ana_rst_req(ana_rst_req),
        .ana_rst_ack(ana_rst_ack), .dig_rst(dig_rst), .busy(busy),
        .done(done), .err(err)
    );

    // ---------------- channel model ----------------
    logic [7:0] mem [256] = '{default: 8'h00};
    logic       wq_seen = 1'b0;
    logic       p1v = 1'b0, p2v = 1'b0;
    logic [7:0] p1d = '0, p2d = '0;
    int         poll_left = 0;
    int         poll_cfg = 0;
    int         wr_cnt = 0, rd_cnt = 0, ana_idx = -1, acnt = 0;
    logic [7:0] log_a [32];
    logic [7:0] log_d [32];
    logic       req_d = 1'b0;
    logic       ack_en = 1'b1;
    int         ack_delay = 2;
    logic       pl_en = 1'b0, log_clr = 1'b0;
    logic [7:0] pl_a = '0, pl_d = '0;

    assign avm_waitrequest   = (avm_read || avm_write) && !wq_seen;
    assign avm_readdatavalid = p2v;
    assign avm_readdata      = p2d;
    assign ana_rst_ack       = ana_rst_req && ack_en && (acnt >= ack_delay);

    always @(posedge clk) begin
        req_d   <= ana_rst_req;
        acnt    <= ana_rst_req ? acnt + 1 : 0;
        wq_seen <= (avm_read || avm_write) && !wq_seen;
        p2v <= p1v; p2d <= p1d; p1v <= 1'b0;
        if (pl_en) mem[pl_a] <= pl_d;
        if (log_clr) begin
            wr_cnt <= 0; rd_cnt <= 0; ana_idx <= -1;
        end else begin
            if (ana_rst_req && !req_d) ana_idx <= wr_cnt;
            if (avm_write && !avm_waitrequest) begin
                if (wr_cnt < 32) begin
                    log_a[wr_cnt] <= avm_address;
                    log_d[wr_cnt] <= avm_writedata;
                end
                wr_cnt <= wr_cnt + 1;
                if (avm_address == 8'h91) poll_left <= poll_cfg;
                else if (avm_address == 8'h8A) mem[8'h8A] <= mem[8'h8A] & ~avm_writedata;
                else mem[avm_address] <= avm_writedata;
            end
            if (avm_read && !avm_waitrequest) begin
                rd_cnt <= rd_cnt + 1;
                p1v    <= 1'b1;
                if (avm_address == 8'h91) begin
                    p1d <= {7'd0, poll_left != 0};
                    if (poll_left != 0) poll_left <= poll_left - 1;
                end else begin
                    p1d <= mem[avm_address];
                end
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, bad = 0;
    int cyc = 0;
    logic [7:0] exp_a [32];
    logic [7:0] exp_d [32];
    int exp_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad++; checks++;
            $display("FAIL watchdog: actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic add_exp(input logic [7:0] a, input logic [7:0] d);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic build_exp(input vec_t v);
        logic [3:0] nib;
        nib = v.lk_hi ? v.lk_val[7:4] : v.lk_val[3:0];
        exp_n = 0;
        add_exp(8'h84, 8'h01); add_exp(8'h86, 8'h01);
        add_exp(8'hEC, {v.mux_init[7:4], nib});
        add_exp(8'h91, 8'h01);
        if (v.new_cfg) begin
            add_exp(8'h8A, 8'h80);
            add_exp(8'h84, v.tx); add_exp(8'h86, 8'h05);
            add_exp(8'h84, v.rx); add_exp(8'h86, 8'h06);
            add_exp(8'h84, v.sd); add_exp(8'h86, 8'h14);
            add_exp(8'h84, v.eq); add_exp(8'h86, 8'h15);
            if (v.cal_en) begin add_exp(8'h84, 8'h01); add_exp(8'h86, 8'h11); end
            add_exp(8'h84, 8'h00); add_exp(8'h86, 8'h01);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pl_en = 1'b1; pl_a = a; pl_d = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic prep(input vec_t v, input int polls);
        poke(v.lk_addr, v.lk_val);
        poke(8'hEC, v.mux_init);
        poke(8'h8A, 8'h85);
        poll_cfg = polls;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        lookup_addr = v.lk_addr; lookup_hi = v.lk_hi; new_cfg = v.new_cfg;
        cal_en = v.cal_en; tx_ratio = v.tx; rx_ratio = v.rx;
        serdes_mode = v.sd; tx_eq = v.eq;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // runs to completion or fault; inj>0 pulses start with altered inputs at that cycle
    task automatic run_wait(input int inj, output int dn, output int gap, output int ok_end);
        dn = 0; gap = 0; ok_end = 0;
        for (int c = 0; c < 4000; c++) begin
            if (done) dn++;
            if (busy && !done && !dig_rst) gap++;
            if (!busy && (dn > 0 || err)) begin ok_end = 1; break; end
            start = (c == inj);
            if (c == inj) begin lookup_hi = ~lookup_hi; new_cfg = ~new_cfg; end
            @(negedge clk);
        end
        start = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done) dn++;
        end
    endtask

    task automatic cmp_log(input string req);
        int first_bad;
        first_bad = -1;
        chk(wr_cnt == exp_n, req, "write count", wr_cnt, exp_n);
        for (int i = 0; i < exp_n && i < wr_cnt; i++)
            if (first_bad < 0 && (log_a[i] != exp_a[i] || log_d[i] != exp_d[i])) first_bad = i;
        if (first_bad >= 0)
            chk(1'b0, req, "write sequence entry",
                {log_a[first_bad], log_d[first_bad]}, {exp_a[first_bad], exp_d[first_bad]});
        else
            chk(1'b1, req, "write sequence", 0, 0);
    endtask

    initial begin
        int dn, gap, ok_end, w0, r0;
        vec_t v;

        repeat (4) @(negedge clk);
        // reset state R1 R10
        chk(!dig_rst && !busy && !done && !err, "R1", "reset outputs",
            {dig_rst, busy, done, err}, 0);
        chk(!avm_read && !avm_write && !ana_rst_req, "R10", "reset bus quiet",
            {avm_read, avm_write, ana_rst_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            wait_limit = 16'd1000; ack_en = 1'b1;
            build_exp(v);
            prep(v, int'(v.polls));
            run_wait(-1, dn, gap, ok_end);
            chk(ok_end == 1 && !err, "R11", "run completes", err, 0);
            chk(dn == 1, "R11", "done pulse count", dn, 1);
            chk(gap == 0, "R1", "dig_rst held while busy", gap, 0);
            chk(!dig_rst, "R1", "dig_rst released", dig_rst, 0);
            // R2 R3 R7 R8 R9 write order and data
            cmp_log(v.new_cfg ? (v.cal_en ? "R7" : "R8") : "R9");
            chk(log_a[0] == 8'h84 && log_a[1] == 8'h86, "R2", "analog reset attribute first",
                {log_a[0], log_a[1]}, 16'h8486);
            chk(mem[8'hEC] == {v.mux_init[7:4], v.lk_hi ? v.lk_val[7:4] : v.lk_val[3:0]},
                "R4", "mux register", mem[8'hEC],
                {v.mux_init[7:4], v.lk_hi ? v.lk_val[7:4] : v.lk_val[3:0]});
            chk(log_d[2][3:0] == (v.lk_hi ? v.lk_val[7:4] : v.lk_val[3:0]), "R3",
                "captured nibble", log_d[2][3:0], v.lk_hi ? v.lk_val[7:4] : v.lk_val[3:0]);
            chk(ana_idx == 3, "R5", "analog request after mux write", ana_idx, 3);
            chk(rd_cnt == 3 + int'(v.polls), "R6", "poll read count", rd_cnt, 3 + int'(v.polls));
            chk(mem[8'h8A] == (v.new_cfg ? 8'h05 : 8'h85), "R7", "flag clear", mem[8'h8A],
                v.new_cfg ? 8'h05 : 8'h85);
        end

        // start while busy is ignored R11
        v = VECS[0];
        build_exp(v);
        prep(v, 2);
        run_wait(6, dn, gap, ok_end);
        chk(dn == 1, "R11", "single done despite second start", dn, 1);
        cmp_log("R11");

        // poll never clears R10
        v = VECS[1];
        wait_limit = 16'd20;
        prep(v, 200);
        run_wait(-1, dn, gap, ok_end);
        chk(err && dig_rst && !busy, "R10", "poll timeout fault", {err, dig_rst, busy}, 3'b110);
        chk(wr_cnt == 4 && dn == 0, "R10", "no writes after poll fault", wr_cnt, 4);
        w0 = wr_cnt; r0 = rd_cnt;
        repeat (30) @(negedge clk);
        chk(wr_cnt == w0 && rd_cnt == r0 && err, "R10", "quiet in fault", rd_cnt, r0);

        // acknowledge never arrives R10 R5
        v = VECS[2];
        wait_limit = 16'd15; ack_en = 1'b0;
        prep(v, 0);
        run_wait(-1, dn, gap, ok_end);
        chk(err && dig_rst && !ana_rst_req, "R10", "ack timeout fault",
            {err, dig_rst, ana_rst_req}, 3'b110);
        chk(wr_cnt == 3 && rd_cnt == 2, "R5", "no traffic without ack", wr_cnt, 3);

        // restart from fault
        v = VECS[1];
        wait_limit = 16'd1000; ack_en = 1'b1;
        build_exp(v);
        prep(v, 1);
        run_wait(-1, dn, gap, ok_end);
        chk(dn == 1 && !err && !dig_rst, "R10", "restart after fault", {dn[1:0], err, dig_rst}, 4'b0100);
        cmp_log("R7");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule